// File: doc/BRIEF.md
# Memory-Driven JTAG Bitstream Player

This block plays back a JTAG bitstream that was recorded ahead of time into a byte-wide memory. It drives the four test pins with no processor and no TAP decoding. One free-running counter runs on the system clock. Its bit fields supply four things: the test clock, the position of the bit inside the current nibble, the memory address, and a final stop bit. Each memory byte holds four consecutive stream bits: the TDI values in the low nibble and the TMS values in the high nibble.

The memory sits outside the block. It sees only an address and returns read data a fixed number of system clocks later, set by the `RD_LAT` parameter. The block delays its bit-select by the same amount, so a memory with any latency lines up with the right bit. The data path has no valid/ready handshake. The memory cannot apply back-pressure, so the only rule is that read data arrives exactly `RD_LAT` clocks after the address. TMS and TDI change early in the low half of each test-clock period, which leaves them settled well before the rising edge that samples them. After the last bit of the top address has been played, counting stops, the test clock stays low and `done` is raised.

Top module: `jtag_stream_player`

## Requirements
- R1: While `rst_n` is low, `tck`, `tms`, `tdi` and `done` are 0 and `mem_addr` is 0.
- R2: In system cycle c after reset release (c clock edges since release), `tck` equals bit `TCK_LOG2-1` of c. The period is 2^TCK_LOG2 clocks (16 by default), and the low half comes first.
- R3: `mem_addr` equals c shifted right by `TCK_LOG2+2`, so each byte is presented for four test-clock periods. The address changes only at the start of a period whose bit position is 0.
- R4: During test-clock period N, `tdi` carries bit (N mod 4) of the byte at address N/4.
- R5: During test-clock period N, `tms` carries bit (N mod 4)+4 of the byte at address N/4.
- R6: `tms` and `tdi` change only `RD_LAT+1` system clocks after the falling edge of `tck` that opens a period. `RD_LAT+1` must be less than half a test-clock period. Until that point they keep the previous period's values.
- R7: After 4·2^ADDR_W test-clock periods, the counter stops. From then on `done` is 1, `tck` is held at 0 and `mem_addr` is held at 0.
- R8: Once stopped, `tms` and `tdi` keep the values of the final stream bit, whatever the memory returns.
- R9: `trst_n` follows `rst_n` with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| mem_rdata | input | 8 | Memory read data, valid RD_LAT clocks after the address |
| mem_addr | output | ADDR_W | Byte address into the stream memory |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data in |
| trst_n | output | 1 | Test reset, active low |
| done | output | 1 | High once the whole memory has been played |

## Verification
Several rules are checked on every cycle. The address may change only where a period's bit position wraps. The pins may change only at the fixed offset after the falling edge of `tck`. A rising `tck` must follow the last low phase count. Once the block has stopped, the counter fields and the pins must stay frozen. Only the bench's scenarios can show that each bit lands at the right nibble position from the right byte. This is done by an exhaustive cycle-by-cycle sweep of a 16-byte memory at two read latencies. The same sweep also shows the reset values, the exact stop cycle, and the pass-through of the test reset.

// File: rtl/jsp_pkg.sv
package jsp_pkg;
  // Stream bits per memory byte half
  localparam int NIB   = 4;
  localparam int SEL_W = $clog2(NIB);

  // One slot of the select path travelling alongside a memory read
  typedef struct packed {
    logic             live;
    logic [SEL_W-1:0] sel;
  } tap_slot_t;
endpackage

// File: rtl/jsp_ticker.sv
module jsp_ticker
  import jsp_pkg::*;
#(
  parameter int TCK_LOG2 = 4,
  parameter int ADDR_W   = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                tck,
  output logic [SEL_W-1:0]    sel,
  output logic [ADDR_W-1:0]   addr,
  output logic [TCK_LOG2-1:0] phase,
  output logic                halted
);
  localparam int SEL_LO   = TCK_LOG2;
  localparam int ADDR_LO  = TCK_LOG2 + SEL_W;
  localparam int STOP_BIT = ADDR_LO + ADDR_W;
  localparam int CNT_W    = STOP_BIT + 1;
  localparam int HALF     = 1 << (TCK_LOG2 - 1);

  logic [CNT_W-1:0] cnt;

  // Free-running until the stop bit sets, then frozen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!cnt[STOP_BIT]) cnt <= cnt + CNT_W'(1);
  end

  assign phase  = cnt[TCK_LOG2-1:0];
  assign tck    = cnt[TCK_LOG2-1];
  assign sel    = cnt[SEL_LO +: SEL_W];
  assign addr   = cnt[ADDR_LO +: ADDR_W];
  assign halted = cnt[STOP_BIT];

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(addr) && !tck));

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != $past(addr)) |-> (phase == '0 && sel == '0));

  // R2
  tck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tck) |-> ($past(phase) == TCK_LOG2'(HALF - 1)));
endmodule

// File: rtl/jsp_align.sv
module jsp_align
  import jsp_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tap_slot_t d,
  output tap_slot_t q
);
  generate
    if (RD_LAT == 0) begin : g_direct
      assign q = d;
    end else begin : g_pipe
      tap_slot_t stage [RD_LAT];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < RD_LAT; i++) stage[i] <= '0;
        end else begin
          stage[0] <= d;
          for (int i = 1; i < RD_LAT; i++) stage[i] <= stage[i-1];
        end
      end
      assign q = stage[RD_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/jsp_lane.sv
module jsp_lane
  import jsp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic [7:0] rdata,
  input  tap_slot_t slot,
  output logic      tms,
  output logic      tdi
);
  // Low nibble feeds TDI, high nibble feeds TMS, same position in both
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tms <= 1'b0;
      tdi <= 1'b0;
    end else if (slot.live) begin
      tdi <= rdata[{1'b0, slot.sel}];
      tms <= rdata[{1'b1, slot.sel}];
    end
  end

  // R8
  frozen_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot.live |=> ($stable(tms) && $stable(tdi)));
endmodule

// File: rtl/jtag_stream_player.sv
module jtag_stream_player
  import jsp_pkg::*;
#(
  parameter int TCK_LOG2 = 4,
  parameter int ADDR_W   = 15,
  parameter int RD_LAT   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              trst_n,
  output logic              done
);
  localparam int HALF = 1 << (TCK_LOG2 - 1);

  generate
    if (RD_LAT + 1 >= HALF) begin : g_bad_latency
      $error("read latency leaves no setup margin before rising tck");
    end
  endgenerate

  logic [SEL_W-1:0]    sel;
  logic [TCK_LOG2-1:0] phase;
  tap_slot_t           slot_now, slot_late;

  jsp_ticker #(.TCK_LOG2(TCK_LOG2), .ADDR_W(ADDR_W)) u_ticker (
    .clk    (clk),
    .rst_n  (rst_n),
    .tck    (tck),
    .sel    (sel),
    .addr   (mem_addr),
    .phase  (phase),
    .halted (done)
  );

  assign slot_now.live = !done;
  assign slot_now.sel  = sel;

  jsp_align #(.RD_LAT(RD_LAT)) u_align (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (slot_now),
    .q     (slot_late)
  );

  jsp_lane u_lane (
    .clk   (clk),
    .rst_n (rst_n),
    .rdata (mem_rdata),
    .slot  (slot_late),
    .tms   (tms),
    .tdi   (tdi)
  );

  assign trst_n = rst_n;

  // R6
  pin_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tms != $past(tms)) || (tdi != $past(tdi))) |->
      (phase == TCK_LOG2'(RD_LAT + 1)));
endmodule

// File: tb/test_jtag_stream_player.sv
`timescale 1ns/1ps
module test_jtag_stream_player;
  localparam int CLK_PERIOD = 50;
  localparam int TCK_LOG2   = 4;
  localparam int ADDR_W     = 4;
  localparam int LAT_A      = 2;
  localparam int LAT_B      = 0;
  localparam int NBITS      = (1 << ADDR_W) * 4;
  localparam int STOP_CYC   = NBITS << TCK_LOG2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  logic rst_n;

  logic [ADDR_W-1:0] addr_a, addr_b;
  logic [7:0] rd_a, rd_b, pa1, pa2;
  logic tck_a, tms_a, tdi_a, trst_a, done_a;
  logic tck_b, tms_b, tdi_b, trst_b, done_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [7:0] pattern(input int i);
    return 8'((i * 53) ^ 166 ^ (i << 4));
  endfunction

  function automatic int stream_bit(input int n, input bit is_tms);
    logic [7:0] b;
    if (n < 0) return 0;
    b = pattern(n >> 2);
    return int'(b[(n & 3) + (is_tms ? 4 : 0)]);
  endfunction

  jtag_stream_player #(.TCK_LOG2(TCK_LOG2), .ADDR_W(ADDR_W), .RD_LAT(LAT_A)) i_jtag_stream_player (
    .clk(clk), .rst_n(rst_n), .mem_rdata(rd_a), .mem_addr(addr_a),
    .tck(tck_a), .tms(tms_a), .tdi(tdi_a), .trst_n(trst_a), .done(done_a));

  jtag_stream_player #(.TCK_LOG2(TCK_LOG2), .ADDR_W(ADDR_W), .RD_LAT(LAT_B)) i_jtag_stream_player_l0 (
    .clk(clk), .rst_n(rst_n), .mem_rdata(rd_b), .mem_addr(addr_b),
    .tck(tck_b), .tms(tms_b), .tdi(tdi_b), .trst_n(trst_b), .done(done_b));

  // Memory with two-cycle read latency
  always_ff @(posedge clk) begin
    pa1 <= pattern(int'(addr_a));
    pa2 <= pa1;
  end
  assign rd_a = pa2;
  // Memory with combinational read
  assign rd_b = pattern(int'(addr_b));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_cycle(input int c, input int lat, input logic tck, input int addr,
                             input logic tms, input logic tdi, input logic done);
    bit running = (c < STOP_CYC);
    int n = c >> TCK_LOG2;
    int ph = c & ((1 << TCK_LOG2) - 1);
    int idx = running ? ((ph >= lat + 1) ? n : n - 1) : NBITS - 1;
    if (running) begin
      check("R2 tck", int'(tck), (c >> (TCK_LOG2 - 1)) & 1);
      check("R3 mem_addr", addr, (c >> (TCK_LOG2 + 2)) & ((1 << ADDR_W) - 1));
      check("R7 done low while running", int'(done), 0);
      check("R4 R6 tdi", int'(tdi), stream_bit(idx, 1'b0));
      check("R5 R6 tms", int'(tms), stream_bit(idx, 1'b1));
    end else begin
      check("R7 tck held", int'(tck), 0);
      check("R7 mem_addr held", addr, 0);
      check("R7 done", int'(done), 1);
      check("R8 tdi frozen", int'(tdi), stream_bit(idx, 1'b0));
      check("R8 tms frozen", int'(tms), stream_bit(idx, 1'b1));
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 reset state on both instances
    check("R1 tck", int'(tck_a), 0);
    check("R1 tms", int'(tms_a), 0);
    check("R1 tdi", int'(tdi_a), 0);
    check("R1 done", int'(done_a), 0);
    check("R1 addr", int'(addr_a), 0);
    check("R1 tck l0", int'(tck_b), 0);
    check("R1 addr l0", int'(addr_b), 0);
    check("R1 done l0", int'(done_b), 0);
    check("R9 trst low", int'(trst_a), 0);
    check("R9 trst low l0", int'(trst_b), 0);
    rst_n = 1'b1;
    #1;
    check("R9 trst high", int'(trst_a), 1);
    check("R9 trst high l0", int'(trst_b), 1);
    for (int c = 1; c <= STOP_CYC + 40; c++) begin
      @(negedge clk);
      check_cycle(c, LAT_A, tck_a, int'(addr_a), tms_a, tdi_a, done_a);
      check_cycle(c, LAT_B, tck_b, int'(addr_b), tms_b, tdi_b, done_b);
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * (STOP_CYC + 500));
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule